// File: doc/BRIEF.md
# DRAM Activation Window Limiter

This block sits beside a DRAM command scheduler and tracks row-activate commands separately for each rank. It keeps a short history of recent activate times for each rank. From that history it tells the scheduler, for every rank, whether a new activate may be issued in the current cycle, and how many cycles remain until one may.

Two rules are enforced together. The first is a minimum gap of `T_RRD` cycles between two activates to the same rank. The second is a cap of `ACT_LIMIT` activates inside any sliding window of `T_XAW` cycles on one rank. Each rank holds its history in a circular buffer of `ACT_LIMIT` timestamps. A new activate overwrites the oldest entry. While the buffer holds `ACT_LIMIT` activates that are all still inside the window, the rank is blocked until the oldest one ages out.

Activates arrive as a strobe carrying a global bank id. The block derives the rank from that id. A strobe to a rank that is currently blocked is still recorded, and it raises a violation flag on the next cycle.

Top module: `awl_limiter`

## Requirements
- R1: After reset every rank reports allowed (`act_ok` bit high, `act_wait` zero) and `act_err` is low.
- R2: The strobe's global bank id selects rank = id / `BANKS_PER_RANK`. With 8 banks per rank, id 8 is rank 1 bank 0 and id 7 is rank 0. An activate changes the state of only the rank it selects.
- R3: After an activate to a rank in cycle t, that rank is blocked until cycle t + `T_RRD`. It is allowed again from that cycle on, provided the window rule permits.
- R4: When a rank has `ACT_LIMIT` activates recorded and the oldest of them, at cycle t0, is still less than `T_XAW` cycles old, the rank is blocked until cycle t0 + `T_XAW`.
- R5: Each new activate replaces the oldest recorded one. After a further activate, the window limit is therefore set by the second-oldest of the previous history.
- R6: `act_wait` for a rank equals the larger of the two remaining gaps (spacing and window), counts down by one per cycle while no activate reaches that rank, and is zero exactly when `act_ok` is high.
- R7: A strobe to a rank whose `act_ok` is low drives `act_err` high for exactly the next cycle. The activate is still recorded. A strobe to an allowed rank leaves `act_err` low.
- R8: Ranks are independent. A rank saturated by the window rule does not block activates to another rank.
- R9: The cycle input is expected to advance by one each clock, modulo 2^`CYC_W`. Activates older than `T_XAW` never constrain a rank, including across a wrap of the cycle input and after idle periods far longer than the stored timestamp width can span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_now | input | CYC_W | Free-running cycle count, advancing by one per clock |
| act_valid | input | 1 | Row-activate strobe |
| act_bank | input | BID_W | Global bank id of the activate |
| act_ok | output | NUM_RANKS | Activate allowed in this cycle, one bit per rank |
| act_wait | output | NUM_RANKS x TS_W | Cycles left until each rank is allowed |
| act_err | output | 1 | An activate was issued to a blocked rank in the previous cycle |

## Verification
The checker enforces several properties on every cycle. A rank that has just received an activate is blocked on the next cycle. A full window always blocks. Each rank's wait count falls by exactly one per cycle without a new activate. The violation flag follows a blocked strobe and stays low when no strobe arrives. At most one rank is selected per strobe. Exact release cycles can only be shown by the directed scenarios, which compare against a reference history kept in absolute time. Those scenarios cover the rolling replacement of the oldest entry, the independence of ranks, the fact that a violating activate is still recorded, and the expiry of stale entries across a counter wrap and a long idle gap.

// File: rtl/awl_pkg.sv
package awl_pkg;

  // Timestamp width: ages up to T_XAW plus one cycle of slack must be
  // distinguishable, with one spare bit against aliasing.
  function automatic int ts_width(input int span);
    return $clog2(span + 1) + 1;
  endfunction

  // Pointer width for a circular buffer; never narrower than one bit.
  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/awl_bank_decode.sv
module awl_bank_decode #(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 8,
  parameter int BID_W          = 4
) (
  input  logic                 strobe,
  input  logic [BID_W-1:0]     bank_id,
  output logic [NUM_RANKS-1:0] rank_hit
);
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    localparam int LO = r * BANKS_PER_RANK;
    localparam int HI = LO + BANKS_PER_RANK;
    always_comb
      rank_hit[r] = strobe && (int'(bank_id) >= LO) && (int'(bank_id) < HI);
  end
endmodule

// File: rtl/awl_rank_hist.sv
module awl_rank_hist #(
  parameter int LIMIT = 4,
  parameter int T_XAW = 20,
  parameter int T_RRD = 4,
  parameter int TS_W  = 6,
  parameter int PTR_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now_ts,
  input  logic            rec,
  output logic            ok,
  output logic [TS_W-1:0] wait_cyc,
  output logic            xaw_full,
  output logic            rrd_busy
);
  localparam logic [TS_W-1:0] XAW_SPAN = TS_W'(T_XAW);
  localparam logic [TS_W-1:0] RRD_SPAN = TS_W'(T_RRD);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(LIMIT - 1);

  function automatic logic [TS_W-1:0] age_of(input logic [TS_W-1:0] now,
                                            input logic [TS_W-1:0] stamp);
    return now - stamp;
  endfunction

  function automatic logic [TS_W-1:0] left_of(input logic [TS_W-1:0] span,
                                             input logic [TS_W-1:0] age);
    return (age >= span) ? '0 : span - age;
  endfunction

  logic [TS_W-1:0]  stamp_q [LIMIT];
  logic [LIMIT-1:0] vld_q;
  logic [LIMIT-1:0] live;
  logic [PTR_W-1:0] wptr_q;
  logic [TS_W-1:0]  last_q;
  logic             last_vld_q;
  logic [TS_W-1:0]  xaw_left;
  logic [TS_W-1:0]  rrd_left;

  for (genvar i = 0; i < LIMIT; i++) begin : g_live
    always_comb live[i] = vld_q[i] && (age_of(now_ts, stamp_q[i]) < XAW_SPAN);
  end

  always_comb begin
    xaw_full = live[wptr_q];
    xaw_left = xaw_full ? left_of(XAW_SPAN, age_of(now_ts, stamp_q[wptr_q])) : '0;
    rrd_busy = last_vld_q && (age_of(now_ts, last_q) < RRD_SPAN);
    rrd_left = rrd_busy ? left_of(RRD_SPAN, age_of(now_ts, last_q)) : '0;
    wait_cyc = (xaw_left > rrd_left) ? xaw_left : rrd_left;
    ok       = !xaw_full && !rrd_busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= '0;
      wptr_q     <= '0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
      for (int i = 0; i < LIMIT; i++) stamp_q[i] <= '0;
    end else begin
      vld_q      <= live;
      last_vld_q <= rrd_busy;
      if (rec) begin
        stamp_q[wptr_q] <= now_ts;
        vld_q[wptr_q]   <= 1'b1;
        wptr_q          <= (wptr_q == LAST_SLOT) ? '0 : wptr_q + 1'b1;
        last_q          <= now_ts;
        last_vld_q      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/awl_limiter.sv
module awl_limiter #(
  parameter int NUM_RANKS      = 2,
  parameter int BANKS_PER_RANK = 8,
  parameter int ACT_LIMIT      = 4,
  parameter int T_XAW          = 20,
  parameter int T_RRD          = 4,
  parameter int CYC_W          = 16,
  localparam int BID_W         = awl_pkg::ptr_width(NUM_RANKS * BANKS_PER_RANK),
  localparam int TS_W          = awl_pkg::ts_width(T_XAW)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CYC_W-1:0]                cyc_now,
  input  logic                            act_valid,
  input  logic [BID_W-1:0]                act_bank,
  output logic [NUM_RANKS-1:0]            act_ok,
  output logic [NUM_RANKS-1:0][TS_W-1:0]  act_wait,
  output logic                            act_err
);
  localparam int PTR_W = awl_pkg::ptr_width(ACT_LIMIT);

  logic [NUM_RANKS-1:0] rank_hit;
  logic [NUM_RANKS-1:0] xaw_full_w;
  logic [NUM_RANKS-1:0] rrd_busy_w;
  logic [TS_W-1:0]      now_ts;
  logic                 blocked_hit;

  assign now_ts = cyc_now[TS_W-1:0];

  awl_bank_decode #(
    .NUM_RANKS(NUM_RANKS), .BANKS_PER_RANK(BANKS_PER_RANK), .BID_W(BID_W)
  ) u_dec (
    .strobe(act_valid), .bank_id(act_bank), .rank_hit(rank_hit)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_hist
    awl_rank_hist #(
      .LIMIT(ACT_LIMIT), .T_XAW(T_XAW), .T_RRD(T_RRD), .TS_W(TS_W), .PTR_W(PTR_W)
    ) u_hist (
      .clk(clk), .rst_n(rst_n), .now_ts(now_ts), .rec(rank_hit[r]),
      .ok(act_ok[r]), .wait_cyc(act_wait[r]),
      .xaw_full(xaw_full_w[r]), .rrd_busy(rrd_busy_w[r])
    );
  end

  assign blocked_hit = |(rank_hit & ~act_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) act_err <= 1'b0;
    else        act_err <= blocked_hit;
  end
endmodule

// File: rtl/awl_checker.sv
module awl_checker #(
  parameter int NUM_RANKS = 2,
  parameter int TS_W      = 6
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           act_valid,
  input logic [NUM_RANKS-1:0]           rank_hit,
  input logic [NUM_RANKS-1:0]           act_ok,
  input logic [NUM_RANKS-1:0][TS_W-1:0] act_wait,
  input logic [NUM_RANKS-1:0]           xaw_full_w,
  input logic                           act_err
);
  a_r2_single_rank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rank_hit) && (act_valid || rank_hit == '0));

  a_r7_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rank_hit & ~act_ok)) |=> act_err);

  a_r7_no_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |=> !act_err);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    a_r3_blocked_after_act: assert property (@(posedge clk) disable iff (!rst_n)
      rank_hit[r] |=> !act_ok[r]);

    a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      xaw_full_w[r] |-> !act_ok[r] && act_wait[r] != '0);

    a_r6_wait_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!rank_hit[r] && act_wait[r] != '0) |=> act_wait[r] == $past(act_wait[r]) - 1'b1);
  end
endmodule

bind awl_limiter awl_checker #(.NUM_RANKS(NUM_RANKS), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .rank_hit(rank_hit),
  .act_ok(act_ok), .act_wait(act_wait), .xaw_full_w(xaw_full_w), .act_err(act_err)
);

// File: tb/tb_awl_limiter.sv
module tb_awl_limiter;
  localparam int CLK_PERIOD = 10;
  localparam int NR    = 2;
  localparam int BPR   = 8;
  localparam int LIM   = 4;
  localparam int XAW   = 20;
  localparam int RRD   = 4;
  localparam int CW    = 16;
  localparam int BW    = 4;
  localparam int TW    = awl_pkg::ts_width(XAW);
  localparam int START = 65280;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_valid = 1'b0;
  logic [BW-1:0] act_bank = '0;
  logic [NR-1:0] act_ok;
  logic [NR-1:0][TW-1:0] act_wait;
  logic act_err;
  int   abs_t = 0;
  logic [CW-1:0] cyc_now;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int hist [NR][LIM];
  int cnt  [NR];
  int wp   [NR];
  int last [NR];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) abs_t <= abs_t + 1;
  assign cyc_now = CW'(abs_t + START);

  awl_limiter #(.NUM_RANKS(NR), .BANKS_PER_RANK(BPR), .ACT_LIMIT(LIM),
                .T_XAW(XAW), .T_RRD(RRD), .CYC_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_now(cyc_now), .act_valid(act_valid),
    .act_bank(act_bank), .act_ok(act_ok), .act_wait(act_wait), .act_err(act_err));

  function automatic int exp_wait(input int r);
    int w = 0;
    if (last[r] >= 0 && last[r] + RRD - abs_t > w) w = last[r] + RRD - abs_t;
    if (cnt[r] == LIM && hist[r][wp[r]] + XAW - abs_t > w) w = hist[r][wp[r]] + XAW - abs_t;
    return w;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", tag, act, exp, abs_t);
    end
  endtask

  task automatic check_rank(input int r, input string tag);
    int w = exp_wait(r);
    check({tag, " ok"}, int'(act_ok[r]), (w == 0) ? 1 : 0);
    check({tag, " wait"}, int'(act_wait[r]), w);
  endtask

  task automatic check_all(input string tag);
    for (int r = 0; r < NR; r++) check_rank(r, tag);
  endtask

  // Drive an activate at the current negedge; return at the next negedge.
  task automatic activate(input int id, input string tag);
    int r = id / BPR;
    int e = (exp_wait(r) != 0) ? 1 : 0;
    act_valid = 1'b1;
    act_bank  = BW'(id);
    hist[r][wp[r]] = abs_t;
    wp[r] = (wp[r] + 1) % LIM;
    if (cnt[r] < LIM) cnt[r]++;
    last[r] = abs_t;
    @(negedge clk);
    act_valid = 1'b0;
    check({tag, " R7 err"}, int'(act_err), e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      check_all(tag);
      @(negedge clk);
    end
  endtask

  task automatic wait_ok(input int r, input string tag);
    while (exp_wait(r) != 0) begin
      check_rank(r, tag);
      @(negedge clk);
    end
    check_rank(r, tag);
  endtask

  task automatic t_reset;
    check_all("R1 reset");
    check("R1 err", int'(act_err), 0);
  endtask

  task automatic t_spacing;
    activate(3, "R3 spacing");
    idle(RRD + 1, "R3 R6 spacing");
  endtask

  task automatic t_window;
    for (int k = 0; k < LIM; k++) begin
      wait_ok(0, "R3 fill");
      activate(k, "R4 fill");
    end
    check("R4 blocked", int'(act_ok[0]), 0);
    wait_ok(0, "R4 window");
  endtask

  task automatic t_drop_oldest;
    activate(5, "R5 fifth");
    wait_ok(0, "R5 second-oldest");
    activate(6, "R5 sixth");
    idle(3, "R5 roll");
  endtask

  task automatic t_decode;
    activate(8, "R2 id8");
    check("R2 rank1 blocked", int'(act_ok[1]), 0);
    check_rank(0, "R2 rank0 untouched");
    idle(RRD, "R2 settle");
    activate(15, "R2 id15");
    check("R2 id15 rank1", int'(act_ok[1]), 0);
    idle(RRD, "R2 settle2");
  endtask

  task automatic t_independent;
    for (int k = 0; k < LIM; k++) begin
      wait_ok(0, "R8 fill");
      activate(1, "R8 fill");
    end
    wait_ok(1, "R8 rank1");
    activate(9, "R8 rank1 act");
    check("R8 rank0 still full", int'(act_ok[0]), 0);
    idle(2, "R8 both");
  endtask

  task automatic t_error;
    wait_ok(0, "R7 pre");
    activate(2, "R7 first");
    activate(4, "R7 violate");
    check("R7 err clears", int'(act_err), 1);
    @(negedge clk);
    check("R7 err one-cycle", int'(act_err), 0);
    check_all("R7 recorded");
  endtask

  task automatic t_stale;
    idle(300, "R9 wrap");
    idle(150, "R9 long idle");
    check_all("R9 free");
    activate(10, "R9 after idle");
    idle(RRD + 1, "R9 fresh");
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      cnt[r] = 0; wp[r] = 0; last[r] = -1000;
      for (int k = 0; k < LIM; k++) hist[r][k] = -1000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_spacing();
    t_window();
    t_drop_oldest();
    t_decode();
    t_independent();
    t_error();
    t_stale();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule